// File: doc/BRIEF.md
# Burst Transmit Power Controller

This block sets the transmit gain of a half-duplex radio one burst at a time. Before a burst, the modem writes the power it wants into a target register. When the burst-start strobe arrives, the block turns that target into a gain code and holds the code steady for the whole burst. While the burst is on the air, the receive converters are otherwise unused. They digitize a copy of the transmitted signal, and the block integrates the energy of those I/Q samples. After the burst-end strobe, a sequential divider forms the mean sample power. A small table maps that mean to a power code in dB, and the code is then presented to the modem with a one-cycle valid pulse.

When the closed loop is switched on, the block compares the measured code with the target that was in force for the burst just sent. The difference is limited to a programmable maximum step and added to a stored correction. That correction takes effect only at the next burst start. The gain code always stays within a 0 to 50 dB span (1 dB per code step).

The controller is a five-state machine:
- IDLE waits for a burst start and takes the START transition to BURST, latching the gain code and the burst's settings.
- BURST accumulates valid samples and takes the END transition to LOAD.
- LOAD hands the totals to the divider and moves to DIVIDE on the next cycle.
- DIVIDE waits for the divider's done flag (the QUOTIENT transition) and moves to UPDATE.
- UPDATE publishes the measurement, steps the correction and returns to IDLE in one cycle.

Top module: `tx_pwr_ctrl`

## Requirements
- R1: After reset, tx_gain, meas_code and meas_valid are 0. The target, the loop enable, the maximum step and the stored correction are also 0.
- R2: A write with wr_addr=0 stores wr_data[5:0] as the target. A write with wr_addr=1 stores wr_data[6] as the loop enable and wr_data[3:0] as the maximum step. tx_gain takes its new value on the clock edge that samples burst_start in IDLE.
- R3: tx_gain does not change from one burst start to the next. Target or configuration writes made during a burst do not alter it.
- R4: A sample counts only when iq_valid is high and the controller is in BURST. That is every cycle after the burst-start cycle, up to and including the burst-end cycle. The mean power is floor(sum(I*I+Q*Q)/N) for N counted samples, and 0 when N is 0.
- R5: Let the mean be P, with its highest set bit at position k, and let f be the two bits just below that bit (zeros fill in when k<2). The dB code is 3*k plus 0, 1, 2, 2 for f = 0, 1, 2, 3. A mean of 0 gives code 0.
- R6: For each burst, meas_valid is high for exactly one cycle, and meas_code carries the new code from that cycle until the next measurement.
- R7: If the loop was enabled at a burst's start, then at its measurement the correction changes by (target - code), limited to plus or minus the maximum step latched at that start. The stored correction saturates at plus or minus 50.
- R8: At a burst start, tx_gain = clamp(target + correction, 0, 50) when the loop is enabled. Otherwise tx_gain = min(target, 50).
- R9: Writing the configuration with the enable bit at 0 clears the correction. A burst started with the loop disabled leaves the correction unchanged.
- R10: burst_start is ignored outside IDLE. burst_end is ignored outside BURST, and no measurement follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the target, 1 selects the loop configuration |
| wr_data | input | 7 | Write data; field layout is given in R2 |
| burst_start | input | 1 | One-cycle strobe that begins a burst |
| burst_end | input | 1 | One-cycle strobe that ends a burst |
| iq_valid | input | 1 | A feedback sample is present |
| iq_i | input | 8 | Feedback in-phase sample, signed |
| iq_q | input | 8 | Feedback quadrature sample, signed |
| tx_gain | output | 6 | Transmit gain code, 1 dB per step |
| meas_code | output | 7 | Measured burst power in dB code |
| meas_valid | output | 1 | One-cycle pulse when meas_code is new |

## Verification
A sweep of every target from 0 to 63 with the loop disabled separates the open-loop pass-through from the saturation at 50. A sweep of every constant amplitude from 0 to 127 covers each octave and each fraction entry of the dB table. Pseudo-random bursts of varied lengths, some with idle gaps and with junk samples placed outside the burst, separate correct sample gating and division from miscounting. Long closed-loop runs push the correction into both saturation limits and exercise the clamps on the step and the gain. Further cases check clearing on disable, a zero step, and strobes or writes issued in the wrong state.

// File: rtl/tx_pwr_pkg.sv
package tx_pwr_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_BURST,
        S_LOAD,
        S_DIVIDE,
        S_UPDATE
    } tpc_state_t;

    // dB increment for the two bits below the leading one of a power value
    function automatic logic [1:0] frac_db(input logic [1:0] f);
        unique case (f)
            2'd0:    frac_db = 2'd0;
            2'd1:    frac_db = 2'd1;
            default: frac_db = 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/tx_pwr_meter.sv
module tx_pwr_meter #(
    parameter int IQW  = 8,
    parameter int CNTW = 10,
    localparam int SQW  = 2 * IQW + 1,
    localparam int ACCW = SQW + CNTW
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   acc_en,
    input  logic signed [IQW-1:0]  iq_i,
    input  logic signed [IQW-1:0]  iq_q,
    input  logic                   load,
    output logic [ACCW-1:0]        mean,
    output logic                   done
);
    localparam int STW = $clog2(ACCW);

    logic [ACCW-1:0]       acc, quo;
    logic [CNTW-1:0]       cnt, rem, rem_nx;
    logic [CNTW:0]         rem_sh;
    logic [STW-1:0]        step;
    logic                  busy, fit;
    logic signed [2*IQW-1:0] ii, qq;
    logic [SQW-1:0]        sq;

    always_comb begin
        ii = iq_i * iq_i;
        qq = iq_q * iq_q;
        sq = SQW'($unsigned(ii)) + SQW'($unsigned(qq));
        rem_sh = {rem, quo[ACCW-1]};
        fit    = rem_sh >= {1'b0, cnt};
        rem_nx = fit ? CNTW'(rem_sh - {1'b0, cnt}) : rem_sh[CNTW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc  <= '0;
            cnt  <= '0;
            quo  <= '0;
            rem  <= '0;
            step <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (clr) begin
                acc <= '0;
                cnt <= '0;
            end else if (acc_en) begin
                acc <= acc + ACCW'(sq);
                cnt <= cnt + 1'b1;
            end
            if (load) begin
                quo  <= acc;
                rem  <= '0;
                step <= '0;
                busy <= 1'b1;
            end else if (busy) begin
                quo <= {quo[ACCW-2:0], fit};
                rem <= rem_nx;
                if (step == STW'(ACCW - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    step <= step + 1'b1;
                end
            end
        end
    end

    assign mean = (cnt == '0) ? '0 : quo;

    // R4: the sample count moves only while the accumulator is enabled or cleared
    assert_count_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_en && !clr) |=> $stable(cnt));

    // R4: a finished quotient never exceeds the accumulated energy
    assert_quotient_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mean <= acc));

endmodule

// File: rtl/tx_pwr_db.sv
module tx_pwr_db
    import tx_pwr_pkg::*;
#(
    parameter int PW  = 27,
    parameter int DBW = 7
) (
    input  logic [PW-1:0]  p,
    output logic [DBW-1:0] code
);
    logic [PW-1:0] sh;
    logic [1:0]    f;
    int            k;

    always_comb begin
        k = 0;
        for (int b = 0; b < PW; b++) begin
            if (p[b]) k = b;
        end
        sh = '0;
        if (k >= 2) begin
            sh = p >> (k - 2);
            f  = sh[1:0];
        end else if (k == 1) begin
            f = {p[0], 1'b0};
        end else begin
            f = 2'd0;
        end
        code = DBW'(3 * k) + DBW'(frac_db(f));
    end

endmodule

// File: rtl/tx_pwr_loop.sv
module tx_pwr_loop #(
    parameter int TW   = 6,
    parameter int DBW  = 7,
    parameter int SW   = 4,
    parameter int GMAX = 50,
    parameter int GW   = 6,
    parameter int CW   = 8
) (
    input  logic [TW-1:0]         tgt_now,
    input  logic                  cl_now,
    input  logic [TW-1:0]         tgt_burst,
    input  logic [DBW-1:0]        meas,
    input  logic [SW-1:0]         max_step,
    input  logic signed [CW-1:0]  corr,
    output logic [GW-1:0]         gain,
    output logic signed [CW-1:0]  corr_next
);
    localparam int EW = ((TW > DBW) ? TW : DBW) + 2;
    localparam logic signed [EW-1:0] GMAX_S = EW'(GMAX);
    localparam logic signed [EW-1:0] ZERO_S = '0;

    logic signed [EW-1:0] tn, tb, mm, lim, ce, err, stp, acc, g;

    always_comb begin
        tn  = EW'(tgt_now);
        tb  = EW'(tgt_burst);
        mm  = EW'(meas);
        lim = EW'(max_step);
        ce  = EW'(corr);
        err = tb - mm;
        if (err > lim)       stp = lim;
        else if (err < -lim) stp = -lim;
        else                 stp = err;
        acc = ce + stp;
        if (acc > GMAX_S)       acc = GMAX_S;
        else if (acc < -GMAX_S) acc = -GMAX_S;
        corr_next = CW'(acc);
        if (cl_now) g = tn + ce;
        else        g = tn;
        if (g > GMAX_S)      g = GMAX_S;
        else if (g < ZERO_S) g = ZERO_S;
        gain = GW'(g);
    end

endmodule

// File: rtl/tx_pwr_ctrl.sv
module tx_pwr_ctrl
    import tx_pwr_pkg::*;
#(
    parameter int IQW  = 8,
    parameter int CNTW = 10,
    parameter int GMAX = 50,
    parameter int TW   = 6,
    parameter int SW   = 4,
    localparam int GW   = $clog2(GMAX + 1),
    localparam int ACCW = 2 * IQW + 1 + CNTW,
    localparam int DBW  = $clog2(3 * ACCW)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  wr_addr,
    input  logic [TW:0]           wr_data,
    input  logic                  burst_start,
    input  logic                  burst_end,
    input  logic                  iq_valid,
    input  logic signed [IQW-1:0] iq_i,
    input  logic signed [IQW-1:0] iq_q,
    output logic [GW-1:0]         tx_gain,
    output logic [DBW-1:0]        meas_code,
    output logic                  meas_valid
);
    localparam int CW = GW + 2;
    localparam int EW = ((TW > DBW) ? TW : DBW) + 2;

    tpc_state_t state, state_nx;

    logic [TW-1:0]        tgt_reg, tgt_b;
    logic                 cl_reg, cl_b;
    logic [SW-1:0]        ms_reg, ms_b;
    logic signed [CW-1:0] corr, corr_next;
    logic [GW-1:0]        gain_new;
    logic [ACCW-1:0]      mean;
    logic [DBW-1:0]       db_code;
    logic                 div_done;
    logic                 start_ok;

    assign start_ok = (state == S_IDLE) && burst_start;

    tx_pwr_meter #(.IQW(IQW), .CNTW(CNTW)) u_meter (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (start_ok),
        .acc_en ((state == S_BURST) && iq_valid),
        .iq_i   (iq_i),
        .iq_q   (iq_q),
        .load   (state == S_LOAD),
        .mean   (mean),
        .done   (div_done)
    );

    tx_pwr_db #(.PW(ACCW), .DBW(DBW)) u_db (
        .p    (mean),
        .code (db_code)
    );

    tx_pwr_loop #(.TW(TW), .DBW(DBW), .SW(SW), .GMAX(GMAX), .GW(GW), .CW(CW)) u_loop (
        .tgt_now   (tgt_reg),
        .cl_now    (cl_reg),
        .tgt_burst (tgt_b),
        .meas      (db_code),
        .max_step  (ms_b),
        .corr      (corr),
        .gain      (gain_new),
        .corr_next (corr_next)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (burst_start) state_nx = S_BURST;
            S_BURST:  if (burst_end)   state_nx = S_LOAD;
            S_LOAD:                    state_nx = S_DIVIDE;
            S_DIVIDE: if (div_done)    state_nx = S_UPDATE;
            S_UPDATE:                  state_nx = S_IDLE;
            default:                   state_nx = S_IDLE;
        endcase
    end

    // registers and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_reg    <= '0;
            cl_reg     <= 1'b0;
            ms_reg     <= '0;
            tgt_b      <= '0;
            cl_b       <= 1'b0;
            ms_b       <= '0;
            corr       <= '0;
            tx_gain    <= '0;
            meas_code  <= '0;
            meas_valid <= 1'b0;
        end else begin
            meas_valid <= 1'b0;
            if (start_ok) begin
                tx_gain <= gain_new;
                tgt_b   <= tgt_reg;
                cl_b    <= cl_reg;
                ms_b    <= ms_reg;
            end
            if (state == S_UPDATE) begin
                meas_code  <= db_code;
                meas_valid <= 1'b1;
                if (cl_b) corr <= corr_next;
            end
            if (wr_en) begin
                if (!wr_addr) begin
                    tgt_reg <= wr_data[TW-1:0];
                end else begin
                    cl_reg <= wr_data[TW];
                    ms_reg <= wr_data[SW-1:0];
                    if (!wr_data[TW]) corr <= '0;
                end
            end
        end
    end

    logic signed [EW-1:0] dcorr, ms_s;
    always_comb begin
        dcorr = EW'(corr_next) - EW'(corr);
        ms_s  = EW'(ms_b);
    end

    assert_gain_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_gain <= GW'(GMAX));

    assert_gain_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |=> $stable(tx_gain));

    assert_step_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_UPDATE && cl_b) |-> (dcorr <= ms_s && dcorr >= -ms_s));

    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid |=> !meas_valid);

    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BURST && !burst_end) |=> (state == S_BURST));

endmodule

// File: tb/tb_tx_pwr_ctrl.sv
module tb_tx_pwr_ctrl;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              wr_addr = 1'b0;
    logic [6:0]        wr_data = '0;
    logic              burst_start = 1'b0;
    logic              burst_end = 1'b0;
    logic              iq_valid = 1'b0;
    logic signed [7:0] iq_i = '0;
    logic signed [7:0] iq_q = '0;
    logic [5:0]        tx_gain;
    logic [6:0]        meas_code;
    logic              meas_valid;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit finished = 0;

    int b_tgt = 0, b_cl = 0, b_ms = 0, b_corr = 0;

    tx_pwr_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .burst_start(burst_start), .burst_end(burst_end), .iq_valid(iq_valid),
        .iq_i(iq_i), .iq_q(iq_q), .tx_gain(tx_gain), .meas_code(meas_code),
        .meas_valid(meas_valid)
    );

    always #10 clk = ~clk;

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic int clampi(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    // dB code from the arithmetic definition in R5
    function automatic int ref_db(input longint p);
        longint v;
        int k, f;
        if (p == 0) return 0;
        v = p; k = 0;
        while (v > 1) begin v = v / 2; k++; end
        f = int'((p * 4) / (longint'(1) << k)) - 4;
        case (f)
            0: return 3 * k;
            1: return 3 * k + 1;
            default: return 3 * k + 2;
        endcase
    endfunction

    task automatic gen(input int mode, input int k, input int seed, output int ii, output int qq);
        case (mode)
            0: begin ii = seed; qq = 0; end
            1: begin ii = seed; qq = -seed; end
            default: begin
                ii = ((k * 37 + seed * 11 + 5) % 256) - 128;
                qq = ((k * 53 + seed * 29 + 3) % 256) - 128;
            end
        endcase
    endtask

    task automatic wr(input bit a, input int d);
        wr_en = 1'b1; wr_addr = a; wr_data = 7'(d);
        @(negedge clk);
        wr_en = 1'b0;
        if (!a) b_tgt = d % 64;
        else begin
            b_cl = (d >> 6) & 1;
            b_ms = d & 15;
            if (b_cl == 0) b_corr = 0;
        end
    endtask

    task automatic run_burst(input int n, input int mode, input int seed,
                             input bit gaps, input bit disturb);
        int bt, bcl, bms, eg, code, ii, qq, seen;
        longint sum;
        bt = b_tgt; bcl = b_cl; bms = b_ms;
        eg = clampi(bt + (bcl != 0 ? b_corr : 0), 0, 50);
        burst_start = 1'b1;
        @(negedge clk);
        burst_start = 1'b0;
        iq_valid = 1'b0;
        chk("R2 R8 gain at burst start", int'(tx_gain), eg);
        sum = 0;
        for (int k = 0; k < n; k++) begin
            if (gaps && (k % 2 == 1)) begin
                iq_valid = 1'b0; iq_i = 8'sd127; iq_q = -8'sd128;
                @(negedge clk);
            end
            if (disturb && k == n / 2) begin
                iq_valid = 1'b0;
                burst_start = 1'b1;
                wr(1'b0, (b_tgt + 17) % 64);
                burst_start = 1'b0;
                chk("R10 R3 gain after mid-burst start and write", int'(tx_gain), eg);
            end
            gen(mode, k, seed, ii, qq);
            iq_valid = 1'b1; iq_i = 8'(ii); iq_q = 8'(qq);
            sum += longint'(ii * ii + qq * qq);
            @(negedge clk);
        end
        iq_valid = 1'b0;
        burst_end = 1'b1;
        @(negedge clk);
        burst_end = 1'b0;
        chk("R3 gain held through burst", int'(tx_gain), eg);
        seen = 0;
        for (int w = 0; w < 100 && seen == 0; w++) begin
            if (meas_valid) seen = 1;
            else @(negedge clk);
        end
        chk("R6 measurement pulse seen", seen, 1);
        code = ref_db((n == 0) ? 0 : sum / n);
        chk("R4 R5 measured code", int'(meas_code), code);
        @(negedge clk);
        chk("R6 pulse lasts one cycle", int'(meas_valid), 0);
        chk("R6 code held after pulse", int'(meas_code), code);
        if (bcl != 0) b_corr = clampi(b_corr + clampi(bt - code, -bms, bms), -50, 50);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000 && !finished) begin
                fails++; checks++;
                $display("FAIL watchdog expired R6 actual=%0d expected=%0d", cycles, 190000);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin : main
        int seen, prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset tx_gain", int'(tx_gain), 0);
        chk("R1 reset meas_code", int'(meas_code), 0);
        chk("R1 reset meas_valid", int'(meas_valid), 0);
        run_burst(2, 0, 5, 0, 0);   // R1: default target 0, loop off

        // R2 R8: every target, loop disabled
        for (int t = 0; t < 64; t++) begin
            wr(1'b0, t);
            run_burst(3, 0, (t * 2) % 128, 0, 0);
        end

        // R5: every constant amplitude
        for (int a = 0; a < 128; a++) run_burst(4, 0, a, 0, 0);
        for (int a = 0; a < 128; a += 9) run_burst(2, 1, a, 0, 0);

        // R4: pseudo-random bursts, varied length, with and without gaps
        for (int s = 0; s < 24; s++) run_burst(1 + s, 2, s, s % 2 == 1, 0);
        run_burst(0, 0, 0, 0, 0);   // R4: empty burst gives 0

        // R4: junk samples outside a burst are ignored
        iq_valid = 1'b1; iq_i = 8'sd127; iq_q = 8'sd127;
        repeat (3) @(negedge clk);
        run_burst(4, 0, 3, 0, 0);

        // R7 R8: closed loop climbs to upper saturation
        wr(1'b1, 64 + 3);
        wr(1'b0, 40);
        for (int b = 0; b < 20; b++) run_burst(2, 0, 0, 0, 0);
        // R7 R8: descends to lower saturation
        wr(1'b0, 10);
        for (int b = 0; b < 40; b++) run_burst(2, 1, 127, 0, 0);
        // R7: zero step freezes correction
        wr(1'b1, 64 + 0);
        for (int b = 0; b < 3; b++) run_burst(3, 2, b, 0, 0);

        // R9: disabling clears the correction; disabled bursts leave it alone
        wr(1'b1, 0);
        run_burst(3, 0, 100, 0, 0);
        wr(1'b1, 64 + 15);
        wr(1'b0, 20);
        run_burst(3, 0, 100, 0, 0);
        for (int b = 0; b < 8; b++) run_burst(4 + b, 2, b + 40, 0, 0);
        wr(1'b1, 64 + 2);
        wr(1'b1, 0);
        chk("R9 model correction cleared", b_corr, 0);
        run_burst(3, 2, 7, 0, 0);

        // R3 R10: start strobe and target write during a burst
        wr(1'b1, 64 + 5);
        run_burst(8, 2, 11, 0, 1);
        run_burst(6, 2, 12, 1, 1);

        // R10: end strobe while idle
        prev = int'(meas_code);
        burst_end = 1'b1;
        @(negedge clk);
        burst_end = 1'b0;
        seen = 0;
        for (int w = 0; w < 40; w++) begin
            if (meas_valid) seen = 1;
            @(negedge clk);
        end
        chk("R10 no measurement from idle end strobe", seen, 0);
        chk("R10 code unchanged after idle end strobe", int'(meas_code), prev);
        run_burst(5, 2, 3, 0, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule